// File: doc/BRIEF.md
# Programmable Audio Clock-Output Divider

The block produces an auxiliary clock from one of four candidate clocks: an internal PLL clock or one of three external clocks (a bit clock, a master clock and a general-purpose clock pin). The output frequency is twice the source frequency divided by M × N. M is one of 1, 2, 4 or 8, and N is any integer from 2 to 17. This gives an overall ratio of M×N/2. When M×N is odd, that ratio is a half-integer.

All four candidate clocks are oversampled by the system clock `clk`. Each one passes through its own synchronizer and edge detector, and the divider counts source half-periods (both edges). A mode bit picks between the PLL and the external set. A two-bit field then picks one of the external clocks.

Settings arrive on a valid/ready configuration port. A transfer happens on a `clk` edge where both `cfg_valid` and `cfg_ready` are high. After a transfer, `cfg_ready` stays low until the new setting takes effect. While `cfg_valid` is high and `cfg_ready` is low, the sender must keep `cfg_valid` high and all `cfg_*` fields stable. A pending setting is applied only where an output period starts, or at once when the divider has no usable source, so no period ever mixes two settings.

Top module: `clkout_divider`

## Requirements
- R1: One output period lasts M×N half-periods of the selected source, so f_out = 2·f_src/(M×N).
- R2: `cfg_m_code` selects M as 0→1, 1→2, 2→4, 3→8.
- R3: `cfg_n` gives N directly for values 2..17. A value below 2 is taken as 2 and a value above 17 is taken as 17.
- R4: With `cfg_ext_mode`=1, `cfg_ext_sel` selects 00→`bclk_in`, 01→`mclk_in`, 10→`gpio_clk_in`, whatever the state of `pll_en`.
- R5: With `cfg_ext_mode`=1 and `cfg_ext_sel`=11, `clk_out` stays low.
- R6: With `cfg_ext_mode`=0, the source is `pll_clk_in` while `pll_en`=1. While `pll_en`=0, `clk_out` is forced low from the next cycle on.
- R7: When M×N is even, `clk_out` is high for exactly half of each period.
- R8: When M×N is odd, `clk_out` is high for (M×N+1)/2 source half-periods and low for (M×N−1)/2.
- R9: A transfer takes place on a `clk` edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low in the cycle after a transfer and stays low until the setting is applied.
- R10: An accepted setting changes nothing in the period in progress. It takes effect at the start of the next period, or immediately when no usable source is selected.
- R11: While `rst_n` is low, `clk_out` is low and the counters are cleared. After reset, `cfg_ready` is high and the active setting is PLL mode with M=1 and N=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples every source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk_in | input | 1 | Internal PLL clock candidate |
| bclk_in | input | 1 | External bit clock candidate |
| mclk_in | input | 1 | External master clock candidate |
| gpio_clk_in | input | 1 | External general-purpose clock candidate |
| pll_en | input | 1 | PLL running indication, synchronous to `clk` |
| cfg_valid | input | 1 | Configuration word is offered |
| cfg_ready | output | 1 | Block can accept a configuration word |
| cfg_ext_mode | input | 1 | 1 = external source set, 0 = PLL clock |
| cfg_ext_sel | input | 2 | External source select (11 reserved) |
| cfg_m_code | input | 2 | M exponent, M = 2^code |
| cfg_n | input | 5 | N value, clamped to 2..17 |
| clk_out | output | 1 | Divided clock output |

## Verification
The assertions assume that each source clock holds every level for at least two `clk` cycles, so that no source edge is lost in the synchronizers. They also assume that `pll_en` is synchronous to `clk`, and that the sender obeys the hold rule while `cfg_valid` is high and `cfg_ready` is low. The stimulus toggles each source on falling `clk` edges with fixed half-periods of 2 to 5 cycles, and it drives `pll_en` on falling edges. It raises `cfg_valid` only after it has seen `cfg_ready` high, and it drops `cfg_valid` one cycle later. The hold condition therefore never comes into play, and every measured period spans a whole number of `clk` cycles.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int M_CODE_W = 2;
  localparam int N_W      = 5;
  localparam int N_MIN    = 2;
  localparam int N_MAX    = 17;
  localparam int SEL_W    = 2;
  localparam int NUM_SRC  = 4;       // three external clocks plus the PLL clock
  localparam int SRC_PLL  = 3;       // index of the PLL clock in the source vector
  localparam int M_MAX    = 1 << ((1 << M_CODE_W) - 1);
  localparam int CNT_W    = $clog2(M_MAX * N_MAX + 2);

  typedef enum logic [SEL_W-1:0] {
    SEL_BCLK = 2'b00,
    SEL_MCLK = 2'b01,
    SEL_GPIO = 2'b10,
    SEL_RSVD = 2'b11
  } ext_sel_e;

  typedef struct packed {
    logic                ext_mode;
    ext_sel_e            sel;
    logic [M_CODE_W-1:0] m_code;
    logic [N_W-1:0]      n_val;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{ext_mode: 1'b0, sel: SEL_BCLK,
                                     m_code: '0, n_val: N_W'(N_MIN)};

  // Half-periods per output period: N * 2^m_code
  function automatic logic [CNT_W-1:0] mn_total(input clk_cfg_t c);
    return CNT_W'(c.n_val) << c.m_code;
  endfunction

  // A setting is usable when it names a running clock
  function automatic logic src_ok(input clk_cfg_t c, input logic pll_on);
    return c.ext_mode ? (c.sel != SEL_RSVD) : pll_on;
  endfunction
endpackage

// File: rtl/clkout_edge_sync.sv
module clkout_edge_sync #(
  parameter int NUM_SRC = 4,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] edge_o
);
  localparam int DEPTH = STAGES + 1;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic [DEPTH-1:0] shreg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[DEPTH-2:0], src_i[g]};
      end
      // Either edge of the synchronized source
      assign edge_o[g] = shreg[DEPTH-1] ^ shreg[DEPTH-2];
    end
  endgenerate
endmodule

// File: rtl/clkout_src_mux.sv
module clkout_src_mux
  import clkout_pkg::*;
(
  input  logic [NUM_SRC-1:0] edges_i,
  input  clk_cfg_t           act_i,
  input  logic               pll_en,
  output logic               src_edge,
  output logic               src_valid
);
  always_comb begin
    src_valid = src_ok(act_i, pll_en);
    if (!src_valid)         src_edge = 1'b0;
    else if (act_i.ext_mode) src_edge = edges_i[act_i.sel];
    else                    src_edge = edges_i[SRC_PLL];
  end
endmodule

// File: rtl/clkout_cfg_reg.sv
module clkout_cfg_reg
  import clkout_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_valid,
  input  clk_cfg_t cfg_in,
  output logic     cfg_ready,
  input  logic     boundary,
  input  logic     src_valid,
  output clk_cfg_t act_o,
  output clk_cfg_t eff_o
);
  clk_cfg_t pend_q, cfg_clamped;
  logic     pending_q, accept, apply;

  always_comb begin
    cfg_clamped = cfg_in;
    if (cfg_in.n_val < N_W'(N_MIN))      cfg_clamped.n_val = N_W'(N_MIN);
    else if (cfg_in.n_val > N_W'(N_MAX)) cfg_clamped.n_val = N_W'(N_MAX);
  end

  assign cfg_ready = !pending_q;
  assign accept    = cfg_valid && !pending_q;
  assign apply     = pending_q && (boundary || !src_valid);
  assign eff_o     = apply ? pend_q : act_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      pend_q    <= CFG_RESET;
      act_o     <= CFG_RESET;
    end else if (accept) begin
      pend_q    <= cfg_clamped;
      pending_q <= 1'b1;
    end else if (apply) begin
      act_o     <= pend_q;
      pending_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clkout_div_core.sv
module clkout_div_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_edge,
  input  logic             src_valid,
  input  logic [CNT_W-1:0] total,
  input  logic             next_valid,
  output logic             boundary,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clk_out
);
  logic             running_q;
  logic [CNT_W:0]   high_wide;
  logic [CNT_W-1:0] high_len, cnt_nxt;

  assign high_wide = ({1'b0, total} + 1'b1) >> 1;
  assign high_len  = high_wide[CNT_W-1:0];
  assign cnt_nxt   = cnt_o + 1'b1;
  assign boundary  = src_valid && src_edge &&
                     (!running_q || (cnt_o == total - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_o     <= '0;
      clk_out   <= 1'b0;
    end else if (!src_valid) begin
      running_q <= 1'b0;
      cnt_o     <= '0;
      clk_out   <= 1'b0;
    end else if (boundary) begin
      running_q <= next_valid;
      cnt_o     <= '0;
      clk_out   <= next_valid;
    end else if (src_edge) begin
      cnt_o     <= cnt_nxt;
      clk_out   <= cnt_nxt < high_len;
    end
  end
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pll_clk_in,
  input  logic                bclk_in,
  input  logic                mclk_in,
  input  logic                gpio_clk_in,
  input  logic                pll_en,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic                cfg_ext_mode,
  input  logic [SEL_W-1:0]    cfg_ext_sel,
  input  logic [M_CODE_W-1:0] cfg_m_code,
  input  logic [N_W-1:0]      cfg_n,
  output logic                clk_out
);
  logic [NUM_SRC-1:0] src_vec, edges;
  clk_cfg_t           cfg_word, act_cfg, eff_cfg;
  logic               src_edge, src_valid, boundary, eff_valid;
  logic [CNT_W-1:0]   act_total, div_cnt;

  assign src_vec   = {pll_clk_in, gpio_clk_in, mclk_in, bclk_in};
  assign cfg_word  = '{ext_mode: cfg_ext_mode, sel: ext_sel_e'(cfg_ext_sel),
                       m_code: cfg_m_code, n_val: cfg_n};
  assign act_total = mn_total(act_cfg);
  assign eff_valid = src_ok(eff_cfg, pll_en);

  clkout_edge_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_i(src_vec), .edge_o(edges));

  clkout_src_mux u_mux (
    .edges_i(edges), .act_i(act_cfg), .pll_en(pll_en),
    .src_edge(src_edge), .src_valid(src_valid));

  clkout_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_in(cfg_word),
    .cfg_ready(cfg_ready), .boundary(boundary), .src_valid(src_valid),
    .act_o(act_cfg), .eff_o(eff_cfg));

  clkout_div_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .src_edge(src_edge), .src_valid(src_valid),
    .total(act_total), .next_valid(eff_valid), .boundary(boundary),
    .cnt_o(div_cnt), .clk_out(clk_out));
endmodule

// File: rtl/clkout_divider_chk.sv
module clkout_divider_chk
  import clkout_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                pll_en,
  input logic                cfg_valid,
  input logic                cfg_ready,
  input logic                cfg_ext_mode,
  input logic [SEL_W-1:0]    cfg_ext_sel,
  input logic [M_CODE_W-1:0] cfg_m_code,
  input logic [N_W-1:0]      cfg_n,
  input logic                clk_out,
  input clk_cfg_t            act_cfg,
  input logic [CNT_W-1:0]    div_cnt,
  input logic [CNT_W-1:0]    act_total
);
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> !cfg_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid &&
      $stable({cfg_ext_mode, cfg_ext_sel, cfg_m_code, cfg_n}));

  p_reserved_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg.ext_mode && act_cfg.sel == SEL_RSVD |-> !clk_out);

  p_pll_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_cfg.ext_mode && !pll_en |=> !clk_out);

  p_apply_at_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg) |-> !clk_out || $rose(clk_out));

  p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < act_total);

  p_n_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg.n_val >= N_W'(N_MIN) && act_cfg.n_val <= N_W'(N_MAX));
endmodule

bind clkout_divider clkout_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .cfg_ext_mode(cfg_ext_mode), .cfg_ext_sel(cfg_ext_sel),
  .cfg_m_code(cfg_m_code), .cfg_n(cfg_n), .clk_out(clk_out),
  .act_cfg(act_cfg), .div_cnt(div_cnt), .act_total(act_total));

// File: tb/sim_clkout_divider.sv
`timescale 1ns/1ps
module sim_clkout_divider;
  localparam int H_BCLK = 2, H_MCLK = 3, H_GPIO = 4, H_PLL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_clk = 1'b0, bclk = 1'b0, mclk = 1'b0, gpio = 1'b0;
  logic pll_en = 1'b0;
  logic cfg_valid = 1'b0, cfg_ext_mode = 1'b0;
  logic [1:0] cfg_ext_sel = 2'b00, cfg_m_code = 2'b00;
  logic [4:0] cfg_n = 5'd2;
  logic cfg_ready, clk_out;
  int n_checks = 0, n_errors = 0;

  always #5 clk = ~clk;

  clkout_divider u0 (
    .clk(clk), .rst_n(rst_n), .pll_clk_in(pll_clk), .bclk_in(bclk),
    .mclk_in(mclk), .gpio_clk_in(gpio), .pll_en(pll_en),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_ext_mode(cfg_ext_mode),
    .cfg_ext_sel(cfg_ext_sel), .cfg_m_code(cfg_m_code), .cfg_n(cfg_n),
    .clk_out(clk_out));

  initial forever begin repeat (H_BCLK) @(negedge clk); bclk = ~bclk; end
  initial forever begin repeat (H_MCLK) @(negedge clk); mclk = ~mclk; end
  initial forever begin repeat (H_GPIO) @(negedge clk); gpio = ~gpio; end
  initial forever begin repeat (H_PLL)  @(negedge clk); pll_clk = ~pll_clk; end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output bit ok);
    logic prev = clk_out;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && clk_out) begin ok = 1'b1; return; end
      prev = clk_out;
    end
  endtask

  // Counts high samples and period from one rising output edge to the next
  task automatic measure(output int hi, output int per);
    bit ok;
    wait_rise(ok);
    hi = 0; per = 0;
    if (!ok) return;
    hi = 1; per = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (clk_out && per > 0 && hi == per && 1'b0) ;
      if (clk_out && hi != per) return;  // new rising edge after a low stretch
      per++;
      if (clk_out) hi++;
    end
  endtask

  task automatic send_cfg(input logic mode, input logic [1:0] sel,
                          input logic [1:0] m, input logic [4:0] n);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1; cfg_ext_mode = mode; cfg_ext_sel = sel;
    cfg_m_code = m; cfg_n = n;
    @(negedge clk);
    cfg_valid = 1'b0;
    for (int i = 0; i < 4000 && !cfg_ready; i++) @(negedge clk);
  endtask

  task automatic expect_div(input string req, input int mn, input int h);
    int hi, per;
    measure(hi, per);
    chk({req, " period"}, per, mn * h);
    chk({req, " high"}, hi, ((mn + 1) / 2) * h);
  endtask

  task automatic count_high(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
  endtask

  task automatic t_reset;
    int highs;
    @(negedge clk);
    chk("R11 clk_out low in reset", int'(clk_out), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", int'(cfg_ready), 1);
    count_high(50, highs);
    chk("R6 R11 pll mode, pll off, stays low", highs, 0);
    pll_en = 1'b1;
    expect_div("R11 R6 default M1 N2 on pll", 2, H_PLL);
  endtask

  task automatic t_sources;
    send_cfg(1'b1, 2'b00, 2'd1, 5'd3);
    expect_div("R4 R7 bclk M2 N3", 6, H_BCLK);
    send_cfg(1'b1, 2'b01, 2'd1, 5'd3);
    expect_div("R4 R7 mclk M2 N3", 6, H_MCLK);
    pll_en = 1'b0;
    send_cfg(1'b1, 2'b10, 2'd1, 5'd3);
    expect_div("R4 R7 gpio M2 N3 pll off", 6, H_GPIO);
    pll_en = 1'b1;
  endtask

  task automatic t_m_codes;
    send_cfg(1'b1, 2'b00, 2'd0, 5'd5);
    expect_div("R2 R8 M1 N5 odd", 5, H_BCLK);
    send_cfg(1'b1, 2'b00, 2'd1, 5'd5);
    expect_div("R2 R7 M2 N5", 10, H_BCLK);
    send_cfg(1'b1, 2'b00, 2'd2, 5'd5);
    expect_div("R2 R7 M4 N5", 20, H_BCLK);
    send_cfg(1'b1, 2'b00, 2'd3, 5'd5);
    expect_div("R2 R7 M8 N5", 40, H_BCLK);
  endtask

  task automatic t_n_range;
    send_cfg(1'b1, 2'b01, 2'd0, 5'd2);
    expect_div("R3 R1 N2", 2, H_MCLK);
    send_cfg(1'b1, 2'b01, 2'd0, 5'd17);
    expect_div("R3 R8 N17", 17, H_MCLK);
    send_cfg(1'b1, 2'b01, 2'd0, 5'd0);
    expect_div("R3 N0 clamps to 2", 2, H_MCLK);
    send_cfg(1'b1, 2'b01, 2'd0, 5'd31);
    expect_div("R3 N31 clamps to 17", 17, H_MCLK);
  endtask

  task automatic t_reserved;
    int highs;
    send_cfg(1'b1, 2'b11, 2'd0, 5'd2);
    count_high(100, highs);
    chk("R5 reserved select holds low", highs, 0);
    send_cfg(1'b1, 2'b00, 2'd0, 5'd2);
    expect_div("R5 R10 leaves reserved at once", 2, H_BCLK);
  endtask

  task automatic t_pll_off;
    int highs;
    send_cfg(1'b0, 2'b00, 2'd0, 5'd3);
    expect_div("R6 pll M1 N3", 3, H_PLL);
    @(negedge clk);
    pll_en = 1'b0;
    @(negedge clk);
    count_high(60, highs);
    chk("R6 pll disabled forces low", highs, 0);
    pll_en = 1'b1;
    expect_div("R6 pll re-enabled", 3, H_PLL);
  endtask

  task automatic t_boundary;
    bit ok;
    int hi, per;
    send_cfg(1'b1, 2'b10, 2'd3, 5'd17);
    wait_rise(ok);
    chk("R10 rise seen", int'(ok), 1);
    hi = 1; per = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (clk_out && hi != per) break;
      per++;
      if (clk_out) hi++;
      if (per == 10) begin
        chk("R9 ready before offer", int'(cfg_ready), 1);
        cfg_valid = 1'b1; cfg_ext_mode = 1'b1; cfg_ext_sel = 2'b10;
        cfg_m_code = 2'd0; cfg_n = 5'd2;
      end
      if (per == 11) begin
        cfg_valid = 1'b0;
        chk("R9 ready low after transfer", int'(cfg_ready), 0);
      end
      if (per == 300) chk("R9 R10 ready low while pending", int'(cfg_ready), 0);
    end
    chk("R10 old period length kept", per, 136 * H_GPIO);
    chk("R10 old high time kept", hi, 68 * H_GPIO);
    expect_div("R10 new setting after boundary", 2, H_GPIO);
  endtask

  initial begin
    t_reset();
    t_sources();
    t_m_codes();
    t_n_range();
    t_reserved();
    t_pll_off();
    t_boundary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule